// File: doc/BRIEF.md
# Transmit Ingress Word Checker

This block sits on the write side of a transmit FIFO. A link-layer device presents one 16-bit word per clock together with a write strobe and five sideband bits: frame start, frame end, word parity, abort request and a pad indication. The block checks parity on every presented word and follows frame boundaries with a three-state machine. It discards words that do not belong to an open frame. For each accepted word it produces one FIFO write carrying the data, an end mark, an abort mark and a count of valid bytes.

There are two framing modes. In packet mode the end, abort and pad inputs are honoured. In cell mode only the frame start matters, and the other three inputs are ignored. The data path can be 16 bits wide or only 8 bits wide (low byte), and parity can be odd or even. All configuration inputs are expected to change only between frames.

The frame machine has three states. `ST_IDLE` means no frame is open. `ST_FRAME` means a frame is being written. `ST_DROP` means a packet was aborted and the block waits for a new start. The transitions are:
- start: `ST_IDLE` or `ST_DROP` to `ST_FRAME` on a start word.
- finish: `ST_FRAME` to `ST_IDLE` on an end word.
- single: a word with both start and end returns to or stays in `ST_IDLE`.
- abort: any state to `ST_DROP` on an abort request.
- hold: every other case keeps the current state.

Top module: `tx_ingress`

## Requirements
- R1: After reset, `wr_en`, `wr_last`, `wr_abort` and `par_err` are 0, and `viol_cnt` is 0.
- R2: In packet mode, a word with `in_sof`=1 opens a packet. It and every following word are written one clock later with `wr_data` equal to `in_data`. The word carrying `in_eof`=1 is written with `wr_last`=1 and closes the packet.
- R3: A strobed word without `in_sof` that arrives while no frame is open and no abort is pending is not written, and `viol_cnt` increases by one (saturating).
- R4: In packet mode, `in_err`=1 inside an open packet writes exactly one entry with `wr_abort`=1, `wr_data`=0, `wr_bytes`=0 and `wr_last`=0. The start and end inputs of that cycle are ignored.
- R5: After an abort, strobed words without `in_sof` are discarded without changing `viol_cnt`. A further `in_err` while discarding writes nothing.
- R6: While discarding, a word with `in_sof`=1 and `in_err`=0 is accepted as the first word of a new packet.
- R7: A word is correct when the count of ones over the 16 data bits plus `in_par` is odd (`cfg_odd_par`=1) or even (`cfg_odd_par`=0). A mismatch pulses `par_err` for one clock, one clock after the word, and the word is still handled normally.
- R8: In packet mode with the 16-bit path, `wr_bytes` is 2 for every word except an end word with `in_pad`=1. Such a word has data only in bits [15:8] and gets `wr_bytes`=1. `in_pad` has no effect on non-end words.
- R9: With `cfg_narrow`=1, every data entry has `wr_bytes`=1 and `in_pad` is ignored.
- R10: In cell mode, `in_eof`, `in_err` and `in_pad` are ignored. Words from a start word onward are written with `wr_last`=0, `wr_abort`=0 and `wr_bytes`=2.
- R11: A cycle with `in_valid`=0 writes nothing, leaves `viol_cnt` unchanged and does not change the frame state, whatever the sideband inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cell_mode | input | 1 | 1 selects cell mode, 0 selects packet mode |
| cfg_odd_par | input | 1 | 1 selects odd parity, 0 selects even parity |
| cfg_narrow | input | 1 | 1 selects the 8-bit data path |
| in_valid | input | 1 | Word strobe |
| in_data | input | 16 | Word data |
| in_sof | input | 1 | Frame start mark |
| in_eof | input | 1 | Packet end mark |
| in_par | input | 1 | Parity bit over in_data |
| in_err | input | 1 | Abort request |
| in_pad | input | 1 | End word holds one byte, in bits [15:8] |
| wr_en | output | 1 | FIFO write strobe |
| wr_data | output | 16 | FIFO write data |
| wr_last | output | 1 | Entry ends a packet |
| wr_abort | output | 1 | Entry marks an aborted packet |
| wr_bytes | output | 2 | Valid byte count of the entry |
| par_err | output | 1 | One-clock parity mismatch flag |
| viol_cnt | output | 8 | Saturating count of stray words |

## Verification
The bench covers several kinds of packets:
- multi-word and single-word packets with both pad values, which separates the pad rule on the end word from the rule for body words;
- an abort request in mid-packet, with start and end held high on the same cycle, which shows that the markers are ignored and that exactly one abort entry is written;
- stray words and a repeated abort request while discarding, which separate the counted idle discard from the silent post-abort discard;
- non-strobed cycles with sideband bits high, which show that state and counter stay put.

It also runs cell mode and the narrow path with the end, abort and pad inputs toggled, and checks bad parity under both parity settings to show that the flag never blocks a write.

// File: rtl/tx_ingress_pkg.sv
package tx_ingress_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FRAME = 2'd1,
        ST_DROP  = 2'd2
    } ing_state_t;
endpackage

// File: rtl/tx_ingress_parity.sv
module tx_ingress_parity #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] data,
    input  logic              par,
    input  logic              odd_sel,
    output logic              bad
);
    logic ones_odd;

    always_comb begin
        ones_odd = (^data) ^ par;
        bad      = odd_sel ? ~ones_odd : ones_odd;
    end
endmodule

// File: rtl/tx_ingress_fsm.sv
module tx_ingress_fsm
    import tx_ingress_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cell_mode,
    input  logic valid,
    input  logic sof,
    input  logic eof,
    input  logic err,
    output logic do_write,
    output logic do_last,
    output logic do_abort,
    output logic do_viol
);
    ing_state_t st, st_nxt;
    logic err_q, eof_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    always_comb begin
        err_q    = err & ~cell_mode;
        eof_q    = eof & ~cell_mode;
        st_nxt   = st;
        do_write = 1'b0;
        do_last  = 1'b0;
        do_abort = 1'b0;
        do_viol  = 1'b0;
        if (valid) begin
            unique case (st)
                ST_IDLE: begin
                    if (err_q) begin
                        st_nxt = ST_DROP;
                    end else if (sof) begin
                        do_write = 1'b1;
                        do_last  = eof_q;
                        st_nxt   = eof_q ? ST_IDLE : ST_FRAME;
                    end else begin
                        do_viol = 1'b1;
                    end
                end
                ST_FRAME: begin
                    if (err_q) begin
                        do_abort = 1'b1;
                        st_nxt   = ST_DROP;
                    end else begin
                        do_write = 1'b1;
                        do_last  = eof_q;
                        if (eof_q) st_nxt = ST_IDLE;
                    end
                end
                ST_DROP: begin
                    if (!err_q && sof) begin
                        do_write = 1'b1;
                        do_last  = eof_q;
                        st_nxt   = eof_q ? ST_IDLE : ST_FRAME;
                    end
                end
                default: st_nxt = ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tx_ingress_wstage.sv
module tx_ingress_wstage #(
    parameter int DATA_W = 16,
    parameter int BCNT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_write,
    input  logic              do_last,
    input  logic              do_abort,
    input  logic              narrow,
    input  logic              pad,
    input  logic              par_bad,
    input  logic              valid,
    input  logic [DATA_W-1:0] data,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_last,
    output logic              wr_abort,
    output logic [BCNT_W-1:0] wr_bytes,
    output logic              par_err
);
    localparam logic [BCNT_W-1:0] FULL_BYTES = BCNT_W'(DATA_W / 8);
    localparam logic [BCNT_W-1:0] ONE_BYTE   = BCNT_W'(1);

    logic [BCNT_W-1:0] bytes_d;

    always_comb begin
        if (do_abort)               bytes_d = '0;
        else if (narrow)            bytes_d = ONE_BYTE;
        else if (do_last && pad)    bytes_d = ONE_BYTE;
        else                        bytes_d = FULL_BYTES;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en    <= 1'b0;
            wr_data  <= '0;
            wr_last  <= 1'b0;
            wr_abort <= 1'b0;
            wr_bytes <= '0;
            par_err  <= 1'b0;
        end else begin
            wr_en    <= do_write | do_abort;
            wr_data  <= do_abort ? '0 : data;
            wr_last  <= do_last & ~do_abort;
            wr_abort <= do_abort;
            wr_bytes <= bytes_d;
            par_err  <= valid & par_bad;
        end
    end
endmodule

// File: rtl/tx_ingress_vcount.sv
module tx_ingress_vcount #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt <= '0;
        else if (inc && ~&cnt)    cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/tx_ingress.sv
module tx_ingress #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8,
    localparam int BCNT_W = $clog2(DATA_W / 8 + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cell_mode,
    input  logic              cfg_odd_par,
    input  logic              cfg_narrow,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic              in_par,
    input  logic              in_err,
    input  logic              in_pad,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_last,
    output logic              wr_abort,
    output logic [BCNT_W-1:0] wr_bytes,
    output logic              par_err,
    output logic [CNT_W-1:0]  viol_cnt
);
    logic par_bad;
    logic do_write, do_last, do_abort, do_viol;

    tx_ingress_parity #(.DATA_W(DATA_W)) u_par (
        .data    (in_data),
        .par     (in_par),
        .odd_sel (cfg_odd_par),
        .bad     (par_bad)
    );

    tx_ingress_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cell_mode (cfg_cell_mode),
        .valid     (in_valid),
        .sof       (in_sof),
        .eof       (in_eof),
        .err       (in_err),
        .do_write  (do_write),
        .do_last   (do_last),
        .do_abort  (do_abort),
        .do_viol   (do_viol)
    );

    tx_ingress_wstage #(.DATA_W(DATA_W), .BCNT_W(BCNT_W)) u_ws (
        .clk      (clk),
        .rst_n    (rst_n),
        .do_write (do_write),
        .do_last  (do_last),
        .do_abort (do_abort),
        .narrow   (cfg_narrow),
        .pad      (in_pad),
        .par_bad  (par_bad),
        .valid    (in_valid),
        .data     (in_data),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .wr_last  (wr_last),
        .wr_abort (wr_abort),
        .wr_bytes (wr_bytes),
        .par_err  (par_err)
    );

    tx_ingress_vcount #(.CNT_W(CNT_W)) u_vc (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (do_viol),
        .cnt   (viol_cnt)
    );
endmodule

// File: rtl/tx_ingress_chk.sv
module tx_ingress_chk #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8,
    parameter int BCNT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_cell_mode,
    input logic              cfg_odd_par,
    input logic              cfg_narrow,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic              in_sof,
    input logic              in_eof,
    input logic              in_par,
    input logic              in_err,
    input logic              in_pad,
    input logic              wr_en,
    input logic              wr_last,
    input logic              wr_abort,
    input logic [BCNT_W-1:0] wr_bytes,
    input logic              par_err,
    input logic [CNT_W-1:0]  viol_cnt
);
    logic mismatch;
    assign mismatch = cfg_odd_par ? ~((^in_data) ^ in_par) : ((^in_data) ^ in_par);

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !wr_en) else $error("AST_IDLE_NO_WRITE"); // R11
    AST_IDLE_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> viol_cnt == $past(viol_cnt)) else $error("AST_IDLE_CNT_HOLD"); // R11
    AST_START_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof && !(in_err && !cfg_cell_mode)) |=> (wr_en && !wr_abort))
        else $error("AST_START_ACCEPTED"); // R6
    AST_ABORT_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_err && !cfg_cell_mode) |=> (!wr_last && (!wr_en || wr_abort)))
        else $error("AST_ABORT_NO_LAST"); // R4
    AST_CELL_NO_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_cell_mode) |=> (!wr_last && !wr_abort))
        else $error("AST_CELL_NO_MARKS"); // R10
    AST_PARITY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mismatch) |=> par_err) else $error("AST_PARITY_FLAG"); // R7
    AST_PAD_ONE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cfg_cell_mode && !cfg_narrow && !in_err && in_eof && in_pad)
        |=> (!wr_en || wr_bytes == BCNT_W'(1))) else $error("AST_PAD_ONE_BYTE"); // R8
    AST_NARROW_ONE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_narrow) |=> (!wr_en || wr_abort || wr_bytes == BCNT_W'(1)))
        else $error("AST_NARROW_ONE_BYTE"); // R9
    AST_CNT_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> viol_cnt >= $past(viol_cnt)) else $error("AST_CNT_MONOTONIC"); // R3
endmodule

bind tx_ingress tx_ingress_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .BCNT_W(BCNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_cell_mode (cfg_cell_mode),
    .cfg_odd_par   (cfg_odd_par),
    .cfg_narrow    (cfg_narrow),
    .in_valid      (in_valid),
    .in_data       (in_data),
    .in_sof        (in_sof),
    .in_eof        (in_eof),
    .in_par        (in_par),
    .in_err        (in_err),
    .in_pad        (in_pad),
    .wr_en         (wr_en),
    .wr_last       (wr_last),
    .wr_abort      (wr_abort),
    .wr_bytes      (wr_bytes),
    .par_err       (par_err),
    .viol_cnt      (viol_cnt)
);

// File: tb/tb_tx_ingress.sv
`timescale 1ns/1ps
module tb_tx_ingress;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_cell_mode = 1'b0, cfg_odd_par = 1'b0, cfg_narrow = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        in_sof = 1'b0, in_eof = 1'b0, in_par = 1'b0, in_err = 1'b0, in_pad = 1'b0;
    logic        wr_en, wr_last, wr_abort, par_err;
    logic [15:0] wr_data;
    logic [1:0]  wr_bytes;
    logic [7:0]  viol_cnt;

    int checks = 0, failures = 0;
    bit done = 0;

    typedef struct {
        logic [15:0] data;
        logic        last;
        logic        abort;
        logic [1:0]  bytes;
        string       tag;
    } exp_t;
    exp_t sb[$];

    int          ref_st = 0;
    logic [7:0]  ref_viol = '0;

    always #10 clk = ~clk;

    tx_ingress dut (
        .clk(clk), .rst_n(rst_n), .cfg_cell_mode(cfg_cell_mode), .cfg_odd_par(cfg_odd_par),
        .cfg_narrow(cfg_narrow), .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof),
        .in_eof(in_eof), .in_par(in_par), .in_err(in_err), .in_pad(in_pad),
        .wr_en(wr_en), .wr_data(wr_data), .wr_last(wr_last), .wr_abort(wr_abort),
        .wr_bytes(wr_bytes), .par_err(par_err), .viol_cnt(viol_cnt)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // monitor: pops expected entries as the design writes
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (sb.size() == 0) begin
                check(0, "R5", "unexpected write data", int'(wr_data), 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(wr_data == e.data && wr_last == e.last && wr_abort == e.abort &&
                      wr_bytes == e.bytes, e.tag, "entry {data,last,abort,bytes}",
                      int'({wr_data, wr_last, wr_abort, wr_bytes}),
                      int'({e.data, e.last, e.abort, e.bytes}));
            end
        end
    end

    // driver with reference model built from the requirements
    task automatic send(input logic [15:0] d, input bit sof, input bit eof, input bit err,
                        input bit pad, input bit badpar, input string tag);
        bit errq, eofq, wr, last, abt;
        logic [1:0] bytes;
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_sof = sof; in_eof = eof; in_err = err; in_pad = pad;
        in_par = (cfg_odd_par ? ~^d : ^d) ^ badpar;
        errq = err && !cfg_cell_mode;
        eofq = eof && !cfg_cell_mode;
        wr = 0; last = 0; abt = 0;
        case (ref_st)
            0: if (errq) ref_st = 2;
               else if (sof) begin wr = 1; last = eofq; ref_st = eofq ? 0 : 1; end
               else if (ref_viol != 8'hFF) ref_viol++;
            1: if (errq) begin abt = 1; ref_st = 2; end
               else begin wr = 1; last = eofq; if (eofq) ref_st = 0; end
            default: if (!errq && sof) begin wr = 1; last = eofq; ref_st = eofq ? 0 : 1; end
        endcase
        if (abt)                bytes = 2'd0;
        else if (cfg_narrow)    bytes = 2'd1;
        else if (last && pad)   bytes = 2'd1;
        else                    bytes = 2'd2;
        if (wr || abt) begin
            e.data = abt ? 16'h0 : d; e.last = last; e.abort = abt; e.bytes = bytes; e.tag = tag;
            sb.push_back(e);
        end
        @(posedge clk); #1;
        check(par_err == badpar, "R7", "par_err", int'(par_err), int'(badpar));
        in_valid = 1'b0;
    endtask

    task automatic gap(input string tag);
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b1; in_eof = 1'b1; in_err = 1'b1; in_pad = 1'b1;
        @(posedge clk); #1;
        check(!wr_en, tag, "wr_en on idle cycle", int'(wr_en), 0);
        in_sof = 1'b0; in_eof = 1'b0; in_err = 1'b0; in_pad = 1'b0;
    endtask

    task automatic check_viol(input string tag);
        @(negedge clk);
        check(viol_cnt == ref_viol, tag, "viol_cnt", int'(viol_cnt), int'(ref_viol));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(!wr_en && !wr_last && !wr_abort && !par_err && viol_cnt == 0, "R1",
              "reset outputs", int'({wr_en, wr_last, wr_abort, par_err, viol_cnt}), 0);
        @(negedge clk); rst_n = 1'b1;
        // R2 / R8 multi-word packet, pad 0 at end
        send(16'h1111, 1, 0, 0, 1, 0, "R8");
        send(16'h2222, 0, 0, 0, 0, 0, "R2");
        send(16'h3333, 0, 1, 0, 0, 0, "R2");
        // R8 single-word packet with pad
        send(16'hAB00, 1, 1, 0, 1, 0, "R8");
        // R3 stray words
        send(16'h4444, 0, 0, 0, 0, 0, "R3");
        send(16'h4445, 0, 1, 0, 0, 0, "R3");
        check_viol("R3");
        // R4 abort mid packet with markers high
        send(16'h5000, 1, 0, 0, 0, 0, "R2");
        send(16'h5001, 0, 0, 0, 0, 0, "R2");
        send(16'h5002, 1, 1, 1, 1, 0, "R4");
        // R5 discard, no count, repeat error silent
        send(16'h6000, 0, 0, 0, 0, 0, "R5");
        send(16'h6001, 0, 1, 1, 0, 0, "R5");
        send(16'h6002, 0, 1, 0, 1, 0, "R5");
        check_viol("R5");
        // R6 start word after abort
        send(16'h7000, 1, 0, 0, 0, 0, "R6");
        // R7 bad parity mid packet, still written
        send(16'h7001, 0, 0, 0, 0, 1, "R7");
        // R11 idle cycles with sideband high keep state
        gap("R11");
        gap("R11");
        check_viol("R11");
        send(16'h7002, 0, 1, 0, 1, 0, "R11");
        // R7 odd parity
        @(negedge clk); cfg_odd_par = 1'b1;
        send(16'h0F0F, 1, 0, 0, 0, 0, "R7");
        send(16'h0001, 0, 0, 0, 0, 1, "R7");
        send(16'hFFFF, 0, 1, 0, 0, 0, "R7");
        // R9 narrow path
        @(negedge clk); cfg_narrow = 1'b1; cfg_odd_par = 1'b0;
        send(16'h0041, 1, 0, 0, 1, 0, "R9");
        send(16'h0042, 0, 1, 0, 0, 0, "R9");
        send(16'h0043, 1, 1, 0, 1, 0, "R9");
        // R10 cell mode
        @(negedge clk); cfg_narrow = 1'b0; cfg_cell_mode = 1'b1;
        send(16'h8888, 0, 0, 0, 0, 0, "R10");
        send(16'h8000, 1, 1, 0, 0, 0, "R10");
        send(16'h8001, 0, 1, 1, 1, 0, "R10");
        send(16'h8002, 0, 0, 1, 0, 0, "R10");
        send(16'h8003, 1, 0, 0, 1, 0, "R10");
        check_viol("R10");
        @(negedge clk); cfg_cell_mode = 1'b0;
        send(16'h9000, 0, 1, 0, 0, 0, "R2");
        check_viol("R3");
        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R2", "pending expected entries", sb.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule